// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block sits between a UART's serial bit stream and an infrared transceiver. It runs from a single-cycle tick at sixteen times the bit rate. In infrared mode the transmit side turns each zero bit into a short high pulse, three ticks long and centred in its bit cell. A one bit leaves the optical line dark, so the transmit output rests low when the link is idle. The receive side watches for pulse edges from the transceiver. It rebuilds an ordinary NRZ stream for the UART receiver by holding its output low for one bit period after each pulse.

A mode bit selects between infrared operation and plain wired pass-through, in which both directions are forwarded untouched. The mode bit takes its value from a strap input on the first clock after reset is released, and software may overwrite it afterwards through a one-cycle write strobe. A separate polarity option inverts the received signal before the decoder, for transceivers that signal a pulse with a low level.

An exact pulse width depends on the tick arriving at a steady integer spacing. A tick derived from a fractional divisor makes the pulse width vary.

Top module: `irda_sir_codec`

## Requirements
- R1: While `ir_mode_o` is 0, `ir_tx_o` equals `uart_txd_i` and `uart_rxd_o` equals `ir_rx_i` in the same cycle, whatever the value of `rx_inv_i`.
- R2: On the first clock edge after `rst_n` rises, the mode bit loads `ir_strap_i`, and `ir_mode_o` shows that value from then on until a write occurs.
- R3: A cycle with `mode_wr_i` = 1 after that first edge sets `ir_mode_o` to `mode_val_i` from the next cycle on. Later changes of `ir_strap_i` leave it unchanged.
- R4: In infrared mode, while `uart_txd_i` stays high, `ir_tx_o` stays low.
- R5: In infrared mode a bit cell starts at the tick where a falling edge of `uart_txd_i` is first seen (cell tick 0), and following cells start every 16 ticks. For a zero bit, `ir_tx_o` is high after cell ticks 7, 8 and 9 and low after every other tick of the cell.
- R6: In infrared mode a one bit inside a frame produces no pulse: `ir_tx_o` stays low for all 16 ticks of its cell.
- R7: In infrared mode, a rise of the decoder input (two synchroniser stages by default) drives `uart_rxd_o` low. It stays low until 16 ticks have been counted after the rise. A new rise restarts the count. With a tick every second clock and the pulse from R5 looped back, sampling after each tick gives low at cell ticks 9 to 15 of a zero cell and at ticks 0 to 7 of the following cell.
- R8: In infrared mode with no pulses arriving, `uart_rxd_o` rests high.
- R9: With `rx_inv_i` = 1, the decoder acts on the inverted `ir_rx_i`, so a low-going pulse decodes exactly as a high-going one does with `rx_inv_i` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16_i | input | 1 | One-cycle pulse at 16x the bit rate |
| ir_strap_i | input | 1 | Strap giving the mode after reset release |
| mode_wr_i | input | 1 | Software write strobe for the mode bit |
| mode_val_i | input | 1 | Mode value written by software (1 = infrared) |
| rx_inv_i | input | 1 | Invert the received signal ahead of the decoder |
| uart_txd_i | input | 1 | NRZ transmit stream from the UART |
| uart_rxd_o | output | 1 | NRZ receive stream to the UART |
| ir_tx_o | output | 1 | Drive to the transceiver emitter |
| ir_rx_i | input | 1 | Signal from the transceiver detector |
| ir_mode_o | output | 1 | Current mode (1 = infrared, 0 = pass-through) |

## Verification
The assertions assume that `tick16_i` lasts a single cycle, and that `uart_txd_i` changes only at cell boundaries, so no falling edge re-aligns the cell counter in the middle of a pulse. They also assume that `rx_inv_i` and the mode change only when the change creates no false edge at the decoder. The bench changes the transmit line only on tick 0 of a cell, with a tick every second clock. It loops the emitter back to the detector through the same polarity that `rx_inv_i` selects, and it flips both at once between frames. This keeps the decoder input free of spurious rises while every byte value crosses the link.

// File: rtl/irda_sir_pkg.sv
package irda_sir_pkg;

   // link mode held by the mode register
   typedef enum logic {
      LINK_WIRED = 1'b0,
      LINK_IR    = 1'b1
   } link_mode_e;

   // counter width that can hold values 0..n-1 (at least one bit)
   function automatic int idx_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   // counter width that can hold values 0..n
   function automatic int cnt_width(input int n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/irda_mode_ctl.sv
module irda_mode_ctl
   import irda_sir_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic strap_i,
   input  logic wr_i,
   input  logic val_i,
   output logic ir_en_o
);

   link_mode_e mode_q;
   logic       armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= LINK_WIRED;
         armed_q <= 1'b0;
      end else if (!armed_q) begin
         mode_q  <= link_mode_e'(strap_i);
         armed_q <= 1'b1;
      end else if (wr_i) begin
         mode_q  <= link_mode_e'(val_i);
      end
   end

   assign ir_en_o = (mode_q == LINK_IR);

   // R2
   strap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |=> (ir_en_o == $past(strap_i)));

   // R3
   sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && wr_i) |=> (ir_en_o == $past(val_i)));

   // R3
   strap_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && !wr_i) |=> $stable(ir_en_o));

endmodule

// File: rtl/irda_sir_enc.sv
module irda_sir_enc
   import irda_sir_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int PULSE_START = 7,
   parameter int PULSE_TICKS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic ir_en_i,
   input  logic nrz_i,
   output logic pulse_o
);

   localparam int IW       = idx_width(OSR);
   localparam int PEND     = PULSE_START + PULSE_TICKS;
   localparam int PSTOP    = PEND % OSR;
   localparam logic [IW-1:0] START_IDX = IW'(PULSE_START);
   localparam logic [IW-1:0] STOP_IDX  = IW'(PSTOP);
   localparam logic [IW-1:0] LAST_IDX  = IW'(OSR - 1);

   logic [IW-1:0] idx_q;
   logic [IW-1:0] idx_nxt;
   logic          nrz_q;
   logic          pulse_q;
   logic          fall;

   // a falling edge only occurs on a cell boundary, so it re-aligns the cell
   assign fall = nrz_q & ~nrz_i;

   always_comb begin
      if (fall) begin
         idx_nxt = '0;
      end else if (idx_q == LAST_IDX) begin
         idx_nxt = '0;
      end else begin
         idx_nxt = idx_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         nrz_q <= 1'b1;
      end else if (tick_i) begin
         idx_q <= idx_nxt;
         nrz_q <= nrz_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q <= 1'b0;
      end else if (!ir_en_i) begin
         pulse_q <= 1'b0;
      end else if (tick_i) begin
         if (idx_nxt == START_IDX) begin
            pulse_q <= ~nrz_i;
         end else if (idx_nxt == STOP_IDX) begin
            pulse_q <= 1'b0;
         end
      end
   end

   assign pulse_o = pulse_q;

   // R5
   pulse_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> ((int'(idx_q) >= PULSE_START) && (int'(idx_q) < PEND)));

   // R5
   pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_q) |-> (idx_q == START_IDX));

   // R4
   idle_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && nrz_i && (idx_nxt == START_IDX)) |=> !pulse_q);

endmodule

// File: rtl/irda_sir_dec.sv
module irda_sir_dec
   import irda_sir_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic ir_en_i,
   input  logic inv_i,
   input  logic ir_i,
   output logic nrz_o
);

   localparam int CW = cnt_width(OSR);
   localparam logic [CW-1:0] LOAD_VAL = CW'(OSR);

   logic          rx_in;
   logic          synced;
   logic          prev_q;
   logic          rise;
   logic [CW-1:0] cnt_q;

   assign rx_in = ir_i ^ inv_i;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign synced = rx_in;
      end else if (SYNC_STAGES == 1) begin : g_sync1
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s_q <= 1'b0;
            end else begin
               s_q <= rx_in;
            end
         end
         assign synced = s_q;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s_q <= '0;
            end else begin
               s_q <= {s_q[SYNC_STAGES-2:0], rx_in};
            end
         end
         assign synced = s_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
      end else begin
         prev_q <= synced;
      end
   end

   assign rise = synced & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!ir_en_i) begin
         cnt_q <= '0;
      end else if (rise) begin
         cnt_q <= LOAD_VAL;
      end else if (tick_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign nrz_o = (cnt_q == '0);

   // R7
   stretch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ir_en_i && rise) |=> !nrz_o);

   // R7
   stretch_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LOAD_VAL);

   // R8
   rest_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nrz_o && !rise) |=> nrz_o);

endmodule

// File: rtl/irda_sir_codec.sv
module irda_sir_codec #(
   parameter int OSR         = 16,
   parameter int PULSE_START = 7,
   parameter int PULSE_TICKS = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick16_i,
   input  logic ir_strap_i,
   input  logic mode_wr_i,
   input  logic mode_val_i,
   input  logic rx_inv_i,
   input  logic uart_txd_i,
   output logic uart_rxd_o,
   output logic ir_tx_o,
   input  logic ir_rx_i,
   output logic ir_mode_o
);

   generate
      if (OSR < 4) begin : g_bad_osr
         $error("OSR must be at least 4");
      end
      if (PULSE_TICKS < 1) begin : g_bad_width
         $error("PULSE_TICKS must be at least 1");
      end
      if (PULSE_START + PULSE_TICKS > OSR) begin : g_bad_pulse
         $error("pulse must end inside its bit cell");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic ir_en;
   logic enc_pulse;
   logic dec_nrz;

   irda_mode_ctl mode_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .strap_i (ir_strap_i),
      .wr_i    (mode_wr_i),
      .val_i   (mode_val_i),
      .ir_en_o (ir_en)
   );

   irda_sir_enc #(
      .OSR         (OSR),
      .PULSE_START (PULSE_START),
      .PULSE_TICKS (PULSE_TICKS)
   ) enc_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick16_i),
      .ir_en_i (ir_en),
      .nrz_i   (uart_txd_i),
      .pulse_o (enc_pulse)
   );

   irda_sir_dec #(
      .OSR         (OSR),
      .SYNC_STAGES (SYNC_STAGES)
   ) dec_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick16_i),
      .ir_en_i (ir_en),
      .inv_i   (rx_inv_i),
      .ir_i    (ir_rx_i),
      .nrz_o   (dec_nrz)
   );

   assign ir_tx_o    = ir_en ? enc_pulse : uart_txd_i;
   assign uart_rxd_o = ir_en ? dec_nrz : ir_rx_i;
   assign ir_mode_o  = ir_en;

   // R1
   wired_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ir_mode_o |-> (ir_tx_o == uart_txd_i));

   // R1
   wired_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ir_mode_o |-> (uart_rxd_o == ir_rx_i));

   // R4
   ir_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ir_mode_o && $past(ir_mode_o) && !$past(enc_pulse) && $stable(uart_txd_i) && uart_txd_i
       && !tick16_i) |-> !ir_tx_o);

endmodule

// File: tb/irda_sir_codec_tb_top.sv
module irda_sir_codec_tb_top;

   logic clk = 1'b0;
   logic rst_n;
   logic tick;
   logic strap;
   logic mwr;
   logic mval;
   logic inv_sel;
   logic txd;
   logic man_rx;
   logic loop_en;
   logic ir_rx;
   logic ir_tx;
   logic rxd;
   logic mode;

   int nvec = 0;
   int nbad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   assign ir_rx = loop_en ? (ir_tx ^ inv_sel) : man_rx;

   irda_sir_codec dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick16_i   (tick),
      .ir_strap_i (strap),
      .mode_wr_i  (mwr),
      .mode_val_i (mval),
      .rx_inv_i   (inv_sel),
      .uart_txd_i (txd),
      .uart_rxd_o (rxd),
      .ir_tx_o    (ir_tx),
      .ir_rx_i    (ir_rx),
      .ir_mode_o  (mode)
   );

   task automatic chk(input logic act, input logic exp, input string req, input string what);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
   endtask

   // one tick: tick high for one clock, sample after its edge
   task automatic one_tick(input logic set_txd, input logic val);
      @(negedge clk);
      tick = 1'b1;
      if (set_txd) txd = val;
      @(negedge clk);
      tick = 1'b0;
   endtask

   logic prev_bit = 1'b1;

   task automatic send_byte(input logic [7:0] b, input string rreq);
      for (int j = 0; j < 10; j++) begin
         logic bitv;
         bitv = (j == 0) ? 1'b0 : ((j == 9) ? 1'b1 : b[j-1]);
         for (int k = 0; k < 16; k++) begin
            logic etx;
            logic erx;
            one_tick(k == 0, bitv);
            etx = (k >= 7) && (k <= 9) && (bitv == 1'b0);
            erx = !(((k >= 9) && (bitv == 1'b0)) || ((k <= 7) && (prev_bit == 1'b0)));
            chk(ir_tx, etx, (bitv == 1'b0) ? "R5" : "R6", "encoder pulse");
            chk(rxd, erx, rreq, "decoded line");
         end
         prev_bit = bitv;
      end
   endtask

   task automatic do_reset(input logic s);
      @(negedge clk);
      rst_n = 1'b0;
      strap = s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      strap = ~s;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog expired: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; tick = 1'b0; strap = 1'b0; mwr = 1'b0; mval = 1'b0;
      inv_sel = 1'b0; txd = 1'b1; man_rx = 1'b0; loop_en = 1'b0;

      // R2: strap 0 sampled at release, later strap change ignored
      do_reset(1'b0);
      chk(mode, 1'b0, "R2", "mode after reset with strap 0");

      // R1: wired pass-through over all input combinations, inversion ignored
      for (int v = 0; v < 8; v++) begin
         @(negedge clk);
         txd = v[0]; man_rx = v[1]; inv_sel = v[2];
         #1;
         chk(ir_tx, txd, "R1", "wired tx");
         chk(rxd, man_rx, "R1", "wired rx");
      end
      @(negedge clk);
      txd = 1'b1; man_rx = 1'b0; inv_sel = 1'b0;

      // R3: software write selects infrared mode
      @(negedge clk); mwr = 1'b1; mval = 1'b1;
      @(negedge clk); mwr = 1'b0;
      chk(mode, 1'b1, "R3", "mode after write");
      strap = 1'b0;
      repeat (3) @(negedge clk);
      strap = 1'b1;
      repeat (3) @(negedge clk);
      chk(mode, 1'b1, "R3", "mode after strap toggles");

      // R4, R8: idle line in infrared mode
      for (int t = 0; t < 40; t++) begin
         one_tick(1'b0, 1'b1);
         chk(ir_tx, 1'b0, "R4", "idle emitter");
         chk(rxd, 1'b1, "R8", "idle decoded line");
      end

      // R5, R6, R7: every byte through the loop, normal polarity
      loop_en = 1'b1;
      for (int b = 0; b < 256; b++) begin
         send_byte(8'(b), "R7");
      end

      // R9: inverted detector polarity, decoder inverts it back
      @(negedge clk);
      inv_sel = 1'b1;
      for (int i = 0; i < 64; i++) begin
         send_byte(8'((i * 37 + 11) & 255), "R9");
      end

      // R2: strap 1 sampled at release
      loop_en = 1'b0;
      inv_sel = 1'b0;
      man_rx = 1'b0;
      do_reset(1'b1);
      chk(mode, 1'b1, "R2", "mode after reset with strap 1");
      for (int t = 0; t < 20; t++) begin
         one_tick(1'b0, 1'b1);
         chk(ir_tx, 1'b0, "R4", "emitter idle after strap reset");
      end

      done = 1;
      summary();
      $finish;
   end

endmodule